// File: doc/BRIEF.md
# Floating-Point Coprocessor Bus Register Block

This block sits on an AHB-Lite bus at base address 0xA016_0000 and connects a CPU to an external floating-point arithmetic unit. It keeps 32 operand registers of 32 bits each, plus one 32-bit control/status word. That word names the two source registers and the destination register, selects single or double precision, carries an 11-bit mode field for the unit, and gathers five sticky exception flags.

The CPU loads operands into the register file with ordinary word writes. It then writes the control/status word, and that write launches one operation. The block builds two 64-bit operands from the named registers and passes them to the unit together with the mode field and the precision bit. When the unit reports completion, the block stores the result in the destination register or registers and ORs the unit's flags into the status word. While an operation is in flight, any further bus access is held in wait states until the result has been stored. A read that follows a launch therefore returns the finished value.

Offset map: 0x00 to 0x7C address register n at offset 4·n, and 0x80 holds the control/status word. Inside that word, bits [4:0] name source A, bits [9:5] name source B, bits [14:10] name the destination, bit [15] set means double precision, bits [26:16] form the mode field, and bits [31:27] hold the flags. Flag bit k of the unit's report lands in word bit 27+k.

Top module: `fpcopSlave`

## Requirements
- R1: During and after reset, hreadyout is 1, hresp is 0, and fpuStart, fpuDouble and fpuCtl are 0. Every register and the control/status word read as 0.
- R2: A word write at base+4·n (n in 0..31) stores hwdata into register n. A word read there returns it. Both complete in their first data-phase cycle with no wait states.
- R3: A write to base+0x80 updates bits [26:0] of the control/status word. Bits [31:27] ignore the bus, and a read of base+0x80 returns the whole word.
- R4: Each write to the control/status word raises fpuStart for exactly one cycle, in the cycle after the write's data phase. In that cycle fpuCtl equals word bits [26:16] and fpuDouble equals bit [15].
- R5: In double precision, operand X (A or B) is {reg[s], reg[(s+1) mod 32]}, where s is the source named for X. In single precision it is {32'h0, reg[s]}.
- R6: On fpuDone in double precision, result[63:32] goes to the destination register d and result[31:0] goes to register (d+1) mod 32. In single precision, result[31:0] goes to d only.
- R7: On each fpuDone, fpuFlags are ORed into word bits [31:27]. Those bits are never cleared except by reset.
- R8: While an operation is pending (from its launch until fpuDone), every data phase is held with hreadyout low and completes in the cycle after fpuDone, and a read then returns the stored result.
- R9: Any transfer outside base+0x00..0x7C and base+0x80, misaligned, or not a word in size gets a two-cycle ERROR response (hresp 1 with hreadyout 0, then hresp 1 with hreadyout 1) and changes no state.
- R10: IDLE or BUSY transfers, and transfers with hsel low, change nothing and see a zero-wait OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from the decoder |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type (bit 1 set = NONSEQ/SEQ) |
| hwrite | input | 1 | 1 = write |
| hsize | input | 3 | Transfer size, only 3'b010 accepted |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus ready, previous transfer done |
| hrdata | output | 32 | Read data (data phase) |
| hreadyout | output | 1 | Slave ready |
| hresp | output | 1 | 1 = ERROR |
| fpuStart | output | 1 | One-cycle launch pulse |
| fpuDouble | output | 1 | Precision select to the unit |
| fpuCtl | output | 11 | Mode field to the unit |
| fpuOpA | output | 64 | Operand A |
| fpuOpB | output | 64 | Operand B |
| fpuResult | input | 64 | Result from the unit |
| fpuFlags | input | 5 | Exception flags from the unit |
| fpuDone | input | 1 | Result valid, one cycle |

## Verification
The operation path runs under four register choices:
- Double precision with interior registers, which separates a correct high/low pairing from a swapped one.
- Single precision, which shows whether the upper half is zeroed and whether a neighbour register is wrongly written.
- All-ones selectors, where both operands and the destination wrap from register 31 to register 0.
- A destination of 31 with a source of 30, so that the low result word has to land in register 0.

Different flag patterns on successive operations tell ORing apart from overwriting, and writing ones into the flag field from the bus shows that the bus cannot set them. Long latencies followed by an immediate read expose missing wait states. Bad offsets, bad sizes, a foreign base and misalignment are each followed by a read of the register they aimed at.

// File: rtl/fpcopPkg.sv
`timescale 1ns/1ps
package fpcopPkg;
  localparam int REG_W  = 32;
  localparam int IDX_W  = 5;
  localparam int NREG   = 1 << IDX_W;
  localparam int SEL_A  = 0;
  localparam int SEL_B  = SEL_A + IDX_W;
  localparam int SEL_D  = SEL_B + IDX_W;
  localparam int DBL    = SEL_D + IDX_W;
  localparam int CTL_LO = DBL + 1;
  localparam int CTL_W  = 11;
  localparam int FLG_LO = CTL_LO + CTL_W;
  localparam int FLG_W  = REG_W - FLG_LO;
  localparam int OP_W   = 2 * REG_W;

  typedef struct packed {
    logic             regWr;
    logic             csrWr;
    logic             wbEn;
    logic             rdCsr;
    logic [IDX_W-1:0] idx;
  } ctlStrb_t;
endpackage

// File: rtl/fpcopCtl.sv
`timescale 1ns/1ps
module fpcopCtl
  import fpcopPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hA016_0000,
  parameter int          OFF_W     = 8,
  parameter int          CSR_OFF   = 'h80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic        hready,
  input  logic        fpuDone,
  output logic        hreadyout,
  output logic        hresp,
  output logic        fpuStart,
  output ctlStrb_t    strb
);
  localparam int REG_SPAN = NREG * 4;
  localparam logic [2:0] WORD_SIZE = 3'b010;

  logic addrPhase, baseHit, regHit, csrHit, sizeOk, reqBad;
  logic dpActive, dpWrite, dpCsr, dpBad, errTail, busy, startQ;
  logic [IDX_W-1:0] dpIdx;
  logic errFirst, dpStall, dpCommit;

  // address-phase decode
  assign addrPhase = hsel && hready && htrans[1];
  assign baseHit   = haddr[31:OFF_W] == BASE_ADDR[31:OFF_W];
  assign regHit    = (haddr[OFF_W-1:0] < OFF_W'(REG_SPAN)) && (haddr[1:0] == 2'b00);
  assign csrHit    = haddr[OFF_W-1:0] == OFF_W'(CSR_OFF);
  assign sizeOk    = hsize == WORD_SIZE;
  assign reqBad    = !(baseHit && sizeOk && (regHit || csrHit));

  // data-phase response
  assign errFirst  = dpActive && dpBad && !errTail;
  assign dpStall   = dpActive && !dpBad && busy;
  assign dpCommit  = dpActive && !dpBad && !busy;
  assign hreadyout = !(errFirst || dpStall);
  assign hresp     = dpActive && dpBad;
  assign fpuStart  = startQ;

  always_comb begin
    strb.regWr = dpCommit && dpWrite && !dpCsr;
    strb.csrWr = dpCommit && dpWrite && dpCsr;
    strb.wbEn  = busy && fpuDone;
    strb.rdCsr = dpCsr;
    strb.idx   = dpIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpActive <= 1'b0;
      dpWrite  <= 1'b0;
      dpCsr    <= 1'b0;
      dpBad    <= 1'b0;
      dpIdx    <= '0;
      errTail  <= 1'b0;
      busy     <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      if (hready) begin
        dpActive <= addrPhase;
        dpWrite  <= hwrite;
        dpCsr    <= csrHit;
        dpBad    <= reqBad;
        dpIdx    <= haddr[IDX_W+1:2];
      end
      errTail <= errFirst;
      startQ  <= strb.csrWr;
      if (strb.csrWr)  busy <= 1'b1;
      else if (fpuDone) busy <= 1'b0;
    end
  end

  // R9
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hresp && !hreadyout) |=> (hresp && hreadyout));
  // R9
  err_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hresp) |-> !hreadyout);
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fpuStart |=> !fpuStart);
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fpuStart |-> busy);
  // R8
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hreadyout && !hresp) |-> busy);
endmodule

// File: rtl/fpcopDp.sv
`timescale 1ns/1ps
module fpcopDp
  import fpcopPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [REG_W-1:0]  wdata,
  input  logic [OP_W-1:0]   fpuResult,
  input  logic [FLG_W-1:0]  fpuFlags,
  output logic [REG_W-1:0]  rdata,
  output logic [OP_W-1:0]   opA,
  output logic [OP_W-1:0]   opB,
  output logic [CTL_W-1:0]  fpuCtl,
  output logic              fpuDouble
);
  logic [REG_W-1:0] rf [NREG];
  logic [REG_W-1:0] csr;
  logic [IDX_W-1:0] selA, selB, selD, selAn, selBn, selDn;
  logic             dbl;

  assign selA  = csr[SEL_A +: IDX_W];
  assign selB  = csr[SEL_B +: IDX_W];
  assign selD  = csr[SEL_D +: IDX_W];
  assign dbl   = csr[DBL];
  assign selAn = selA + IDX_W'(1);
  assign selBn = selB + IDX_W'(1);
  assign selDn = selD + IDX_W'(1);

  assign fpuCtl    = csr[CTL_LO +: CTL_W];
  assign fpuDouble = dbl;
  assign opA = dbl ? {rf[selA], rf[selAn]} : {{REG_W{1'b0}}, rf[selA]};
  assign opB = dbl ? {rf[selB], rf[selBn]} : {{REG_W{1'b0}}, rf[selB]};
  assign rdata = strb.rdCsr ? csr : rf[strb.idx];

  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [REG_W-1:0] q;
    logic hitBus, hitHi, hitLo;
    assign hitBus = strb.regWr && (strb.idx == IDX_W'(g));
    assign hitHi  = strb.wbEn && (selD == IDX_W'(g));
    assign hitLo  = strb.wbEn && dbl && (selDn == IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       q <= '0;
      else if (hitBus) q <= wdata;
      else if (hitHi)  q <= dbl ? fpuResult[OP_W-1:REG_W] : fpuResult[REG_W-1:0];
      else if (hitLo)  q <= fpuResult[REG_W-1:0];
    end
    assign rf[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csr <= '0;
    else begin
      if (strb.csrWr) csr[FLG_LO-1:0] <= wdata[FLG_LO-1:0];
      if (strb.wbEn)  csr[REG_W-1:FLG_LO] <= csr[REG_W-1:FLG_LO] | fpuFlags;
    end
  end

  // R7
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csr[REG_W-1:FLG_LO] & $past(csr[REG_W-1:FLG_LO])) == $past(csr[REG_W-1:FLG_LO]));
  // R3
  flags_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wbEn) |-> csr[REG_W-1:FLG_LO] == $past(csr[REG_W-1:FLG_LO]));
  // R3
  csr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.csrWr |=> csr[FLG_LO-1:0] == $past(wdata[FLG_LO-1:0]));
  // R6
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.regWr && strb.wbEn));
endmodule

// File: rtl/fpcopSlave.sv
`timescale 1ns/1ps
module fpcopSlave
  import fpcopPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hA016_0000
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic [31:0] hwdata,
  input  logic        hready,
  output logic [31:0] hrdata,
  output logic        hreadyout,
  output logic        hresp,
  output logic        fpuStart,
  output logic        fpuDouble,
  output logic [10:0] fpuCtl,
  output logic [63:0] fpuOpA,
  output logic [63:0] fpuOpB,
  input  logic [63:0] fpuResult,
  input  logic [4:0]  fpuFlags,
  input  logic        fpuDone
);
  ctlStrb_t strb;

  fpcopCtl #(.BASE_ADDR(BASE_ADDR)) uCtl (
    .clk(hclk), .rstN(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .fpuDone(fpuDone),
    .hreadyout(hreadyout), .hresp(hresp), .fpuStart(fpuStart), .strb(strb)
  );

  fpcopDp uDp (
    .clk(hclk), .rstN(hresetn), .strb(strb), .wdata(hwdata),
    .fpuResult(fpuResult), .fpuFlags(fpuFlags), .rdata(hrdata),
    .opA(fpuOpA), .opB(fpuOpB), .fpuCtl(fpuCtl), .fpuDouble(fpuDouble)
  );
endmodule

// File: tb/sim_fpcopSlave.sv
`timescale 1ns/1ps
module sim_fpcopSlave;
  localparam logic [31:0] BASE  = 32'hA016_0000;
  localparam logic [31:0] CSR_A = BASE + 32'h80;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic        hsel = 0, hwrite = 0;
  logic [31:0] haddr = 0, hwdata = 0;
  logic [1:0]  htrans = 0;
  logic [2:0]  hsize = 3'b010;
  logic        hready;
  logic [31:0] hrdata;
  logic        hreadyout, hresp, fpuStart, fpuDouble;
  logic [10:0] fpuCtl;
  logic [63:0] fpuOpA, fpuOpB;
  logic [63:0] fpuResult = 0;
  logic [4:0]  fpuFlags = 0;
  logic        fpuDone = 0;

  assign hready = hreadyout;

  fpcopSlave u0 (
    .hclk(clk), .hresetn(rstN), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
    .fpuStart(fpuStart), .fpuDouble(fpuDouble), .fpuCtl(fpuCtl),
    .fpuOpA(fpuOpA), .fpuOpB(fpuOpB), .fpuResult(fpuResult),
    .fpuFlags(fpuFlags), .fpuDone(fpuDone)
  );

  int total = 0, bad = 0;
  logic [31:0] shadow [32];
  logic [31:0] csrExp = 0;
  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdPhase = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // arithmetic unit model: sum of operands after a set latency
  int          modelLat = 2;
  logic [4:0]  modelFlags = 0;
  logic [63:0] capA = 0, capB = 0;
  logic        mActive = 0;
  int          mCnt = 0;
  always @(posedge clk) begin
    fpuDone <= 1'b0;
    if (fpuStart) begin
      capA <= fpuOpA; capB <= fpuOpB; mCnt <= modelLat; mActive <= 1'b1;
    end else if (mActive) begin
      if (mCnt <= 1) begin
        fpuDone <= 1'b1; fpuResult <= capA + capB; fpuFlags <= modelFlags; mActive <= 1'b0;
      end else mCnt <= mCnt - 1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rdPhase && hreadyout && !hresp) begin
      if (expQ.size() == 0) chk(1'b0, "R2 scoreboard underflow", 64'(hrdata), 0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(hrdata == e, t, 64'(hrdata), 64'(e));
      end
    end
  end

  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                      input logic [2:0] size, input logic [1:0] trans, input logic sel,
                      output int stalls, output logic errOut, output logic shapeOk);
    logic firstErr;
    @(posedge clk); #1;
    hsel = sel; htrans = trans; haddr = addr; hwrite = wr; hsize = size;
    @(posedge clk); #1;
    hsel = 0; htrans = 2'b00; hwdata = data; rdPhase = !wr && sel && trans[1];
    stalls = 0; firstErr = 0;
    forever begin
      @(negedge clk);
      if (hreadyout) break;
      stalls++;
      if (hresp) firstErr = 1;
      if (stalls > 60) break;
    end
    errOut  = hresp;
    shapeOk = (firstErr == hresp) && (!hresp || stalls == 1);
    @(posedge clk); #1;
    rdPhase = 0;
  endtask

  task automatic wr32(input logic [31:0] addr, input logic [31:0] data);
    int s; logic e, sh;
    xfer(1'b1, addr, data, 3'b010, 2'b10, 1'b1, s, e, sh);
  endtask

  task automatic rd32(input logic [31:0] addr, input logic [31:0] exp, input string tag, output int stalls);
    logic e, sh;
    expQ.push_back(exp); tagQ.push_back(tag);
    xfer(1'b0, addr, 32'h0, 3'b010, 2'b10, 1'b1, stalls, e, sh);
  endtask

  task automatic runOp(input logic [31:0] val, input logic [4:0] flg, input int lat);
    logic [4:0] a, b, d, an, bn, dn;
    logic dbl;
    logic [63:0] eA, eB, res;
    int s;
    a = val[4:0]; b = val[9:5]; d = val[14:10]; dbl = val[15];
    an = a + 5'd1; bn = b + 5'd1; dn = d + 5'd1;
    eA = dbl ? {shadow[a], shadow[an]} : {32'h0, shadow[a]};
    eB = dbl ? {shadow[b], shadow[bn]} : {32'h0, shadow[b]};
    res = eA + eB;
    modelFlags = flg; modelLat = lat;
    wr32(CSR_A, val);
    @(negedge clk);
    chk(fpuStart == 1'b1, "R4 launch pulse", 64'(fpuStart), 1);
    chk(fpuCtl == val[26:16] && fpuDouble == val[15], "R4 mode fields",
        {52'h0, fpuDouble, fpuCtl}, {52'h0, val[15], val[26:16]});
    @(negedge clk);
    chk(fpuStart == 1'b0, "R4 pulse width", 64'(fpuStart), 0);
    if (dbl) begin
      shadow[d] = res[63:32]; shadow[dn] = res[31:0];
    end else shadow[d] = res[31:0];
    csrExp = {csrExp[31:27] | flg, val[26:0]};
    rd32(BASE + {25'h0, d, 2'b00}, shadow[d], "R6 dest register", s);
    if (lat >= 4) chk(s > 0, "R8 wait states while pending", 64'(s), 1);
    chk(capA == eA, "R5 operand A", capA, eA);
    chk(capB == eB, "R5 operand B", capB, eB);
    if (dbl) rd32(BASE + {25'h0, dn, 2'b00}, shadow[dn], "R6 dest low word", s);
    else rd32(BASE + {25'h0, dn, 2'b00}, shadow[dn], "R6 neighbour untouched", s);
    rd32(CSR_A, csrExp, "R7 sticky flags in status word", s);
  endtask

  task automatic errCase(input logic wr, input logic [31:0] addr, input logic [2:0] size, input string tag);
    int s; logic e, sh;
    xfer(wr, addr, 32'h5A5A_5A5A, size, 2'b10, 1'b1, s, e, sh);
    chk(e && sh, tag, {62'h0, e, sh}, 3);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "R8 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s; logic e, sh;
    for (int i = 0; i < 32; i++) shadow[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hreadyout == 1'b1 && hresp == 1'b0, "R1 bus idle after reset", {hreadyout, hresp}, 2);
    chk(fpuStart == 0 && fpuDouble == 0 && fpuCtl == 0, "R1 unit outputs after reset",
        {fpuStart, fpuDouble, fpuCtl}, 0);
    rd32(BASE, 32'h0, "R1 register 0 after reset", s);
    rd32(BASE + 32'h7C, 32'h0, "R1 register 31 after reset", s);
    rd32(CSR_A, 32'h0, "R1 status word after reset", s);

    // R2 register file fill and readback
    for (int i = 0; i < 32; i++) begin
      shadow[i] = 32'h9E37_79B9 * (i + 1);
      wr32(BASE + 32'(i * 4), shadow[i]);
    end
    for (int i = 0; i < 32; i += 3) begin
      rd32(BASE + 32'(i * 4), shadow[i], "R2 register readback", s);
      chk(s == 0, "R2 zero wait", 64'(s), 0);
    end

    // operations
    runOp((32'h00B << 16) | (32'h1 << 15) | (32'd10 << 10) | (32'd5 << 5) | 32'd2, 5'b00001, 2);
    runOp((32'h4A0 << 16) | (32'd3 << 10) | (32'd8 << 5) | 32'd7, 5'b10000, 6);
    runOp(32'hFFFF_FFFF, 5'b00000, 3);   // R3: bus ones into flag field ignored
    runOp((32'h1 << 15) | (32'd31 << 10) | (32'd0 << 5) | 32'd30, 5'b00110, 1);

    // R9 errors, each followed by a readback of the target
    errCase(1'b1, BASE + 32'h84, 3'b010, "R9 write beyond status word");
    rd32(CSR_A, csrExp, "R9 status word unchanged", s);
    errCase(1'b1, BASE + 32'h0C, 3'b001, "R9 halfword write");
    rd32(BASE + 32'h0C, shadow[3], "R9 register 3 unchanged", s);
    errCase(1'b0, 32'hA017_0000, 3'b010, "R9 foreign base");
    errCase(1'b1, BASE + 32'h12, 3'b010, "R9 misaligned write");
    rd32(BASE + 32'h10, shadow[4], "R9 register 4 unchanged", s);
    errCase(1'b1, BASE + 32'h80, 3'b000, "R9 byte write to status word");
    chk(fpuStart == 0, "R9 no launch on error", 64'(fpuStart), 0);

    // R10 idle, busy and unselected transfers
    xfer(1'b1, BASE + 32'h14, 32'hDEAD_BEEF, 3'b010, 2'b00, 1'b1, s, e, sh);
    chk(!e && s == 0, "R10 idle transfer okay", {e, 32'(s)}, 0);
    xfer(1'b1, BASE + 32'h14, 32'hDEAD_BEEF, 3'b010, 2'b01, 1'b1, s, e, sh);
    chk(!e && s == 0, "R10 busy transfer okay", {e, 32'(s)}, 0);
    xfer(1'b1, BASE + 32'h14, 32'hDEAD_BEEF, 3'b010, 2'b10, 1'b0, s, e, sh);
    chk(!e && s == 0, "R10 unselected okay", {e, 32'(s)}, 0);
    xfer(1'b1, CSR_A, 32'h0000_8000, 3'b010, 2'b10, 1'b0, s, e, sh);
    chk(fpuStart == 0, "R10 no launch when unselected", 64'(fpuStart), 0);
    rd32(BASE + 32'h14, shadow[5], "R10 register 5 unchanged", s);

    // R7 flags cleared only by reset
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    csrExp = 0;
    rd32(CSR_A, 32'h0, "R7 flags cleared by reset", s);

    repeat (2) @(posedge clk);
    chk(expQ.size() == 0, "R2 scoreboard drained", 64'(expQ.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule